// File: doc/BRIEF.md
# Hysteretic Fast-Detect Threshold Monitor

This block sits at the output of a data converter and raises a warning flag when the input is about to clip, so that gain control can switch in attenuation before overdrive occurs. Each signed sample is reduced to its magnitude. The magnitude is compared with a programmable upper level that sets the flag and with a programmable lower level that is used to clear it. The thresholds are unsigned and scaled so that 2^13 is full scale for the default 14-bit sample.

The flag has hysteresis. It rises a fixed number of clocks after a sample whose magnitude goes above the upper level. It falls only after the magnitude has stayed under the lower level for a programmable number of consecutive valid samples. Any valid sample at or above the lower level while the flag is set restarts that dwell count. The thresholds and the dwell length are captured together with each sample, so a change applies cleanly from the next sample onward.

Top module: `thresh_flag_monitor`

## Requirements
- R1: Magnitude is taken as absolute value, so a sample of -x gives the same flag behaviour as +x.
- R2: The most negative code (-8192 at default width) has magnitude 8191, not 0. With an upper threshold of 8190 it sets the flag, and with 8191 it does not.
- R3: A valid sample sets the flag only when its magnitude is strictly greater than the upper threshold. A magnitude equal to the upper threshold does not set it.
- R4: A valid sample is captured at clock edge E. If it sets the flag, `fast_flag` is high after edge E+3, which is 4 clock cycles after the sample is presented, and it is still low after edge E+2.
- R5: While no valid sample has exceeded the upper threshold since reset or since the last clear, the flag stays low.
- R6: A set flag clears after D consecutive valid samples whose magnitude is strictly less than the lower threshold, where D is the dwell value. It falls with the same 4-cycle latency, counted from the D-th such sample.
- R7: While the flag is set, a valid sample with magnitude at or above the lower threshold restarts the dwell count from zero and keeps the flag set.
- R8: A dwell value of 0 behaves like 1: a single valid sample below the lower threshold clears the flag.
- R9: Cycles with `smp_valid` low are ignored. They neither set the flag nor advance or restart the dwell count, whatever the value on `smp_data`.
- R10: Synchronous active-high reset clears the flag, the dwell count and every pipeline stage. A sample that is in flight when reset is asserted never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Marks `smp_data` as a sample in this cycle |
| smp_data | input | 14 | Two's-complement converter sample |
| thr_upper | input | 15 | Upper magnitude level that sets the flag |
| thr_lower | input | 15 | Lower magnitude level used for clearing |
| dwell_len | input | 16 | Consecutive below-lower samples needed to clear (0 acts as 1) |
| fast_flag | output | 1 | Registered near-clipping warning |

## Verification
The hardest state to reach from the ports is a dwell count that is partly run when it is interrupted by a sample between the two thresholds, by invalid cycles carrying large data, or by a reset while a sample is still in the pipeline. The stimulus reaches it with directed sequences that stop one sample short of the dwell length before inserting the disturbing sample. A long seeded random run then picks small dwell values and draws samples from buckets around each threshold and at both extreme codes, so that interrupted and completed dwell runs happen many times.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

  // classification of one sample magnitude against the two levels
  typedef enum logic [1:0] {
    CMP_MID   = 2'd0,
    CMP_ABOVE = 2'd1,
    CMP_BELOW = 2'd2
  } cmp_cls_e;

endpackage

// File: rtl/fdm_magnitude.sv
module fdm_magnitude #(
  parameter int DATA_W  = 14,
  parameter int THR_W   = 15,
  parameter int DWELL_W = 16,
  localparam int MAG_W  = DATA_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [THR_W-1:0]   in_up,
  input  logic [THR_W-1:0]   in_lo,
  input  logic [DWELL_W-1:0] in_dw,
  output logic               q_valid,
  output logic [MAG_W-1:0]   q_mag,
  output logic [THR_W-1:0]   q_up,
  output logic [THR_W-1:0]   q_lo,
  output logic [DWELL_W-1:0] q_dw
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] negated;
  logic [MAG_W-1:0]  mag_c;

  always_comb begin
    negated = ~in_data + 1'b1;
    if (!in_data[DATA_W-1])
      mag_c = in_data[MAG_W-1:0];
    else if (in_data == MOST_NEG)
      mag_c = {MAG_W{1'b1}};
    else
      mag_c = negated[MAG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_mag   <= '0;
      q_up    <= '0;
      q_lo    <= '0;
      q_dw    <= '0;
    end else begin
      q_valid <= in_valid;
      q_mag   <= mag_c;
      q_up    <= in_up;
      q_lo    <= in_lo;
      q_dw    <= in_dw;
    end
  end

  // R2: most negative code saturates to the largest magnitude
  a_r2_min_saturates: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == MOST_NEG) |=> (q_valid && q_mag == {MAG_W{1'b1}}));

endmodule

// File: rtl/fdm_classify.sv
module fdm_classify
  import fdm_pkg::*;
#(
  parameter int MAG_W        = 13,
  parameter int THR_W        = 15,
  parameter int DWELL_W      = 16,
  parameter int EXTRA_STAGES = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [MAG_W-1:0]   in_mag,
  input  logic [THR_W-1:0]   in_up,
  input  logic [THR_W-1:0]   in_lo,
  input  logic [DWELL_W-1:0] in_dw,
  output logic               o_valid,
  output cmp_cls_e           o_cls,
  output logic [DWELL_W-1:0] o_dw
);

  logic [THR_W-1:0] mag_ext;
  cmp_cls_e         cls_c;

  always_comb begin
    mag_ext = THR_W'(in_mag);
    if (mag_ext > in_up)
      cls_c = CMP_ABOVE;
    else if (mag_ext < in_lo)
      cls_c = CMP_BELOW;
    else
      cls_c = CMP_MID;
  end

  // stage index 0 is the compare register, further entries pad the latency
  logic               st_v   [0:EXTRA_STAGES];
  cmp_cls_e           st_cls [0:EXTRA_STAGES];
  logic [DWELL_W-1:0] st_dw  [0:EXTRA_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v[0]   <= 1'b0;
      st_cls[0] <= CMP_MID;
      st_dw[0]  <= DWELL_W'(1);
    end else begin
      st_v[0]   <= in_valid;
      st_cls[0] <= cls_c;
      st_dw[0]  <= (in_dw == '0) ? DWELL_W'(1) : in_dw;
    end
  end

  for (genvar s = 1; s <= EXTRA_STAGES; s++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        st_v[s]   <= 1'b0;
        st_cls[s] <= CMP_MID;
        st_dw[s]  <= DWELL_W'(1);
      end else begin
        st_v[s]   <= st_v[s-1];
        st_cls[s] <= st_cls[s-1];
        st_dw[s]  <= st_dw[s-1];
      end
    end
  end

  assign o_valid = st_v[EXTRA_STAGES];
  assign o_cls   = st_cls[EXTRA_STAGES];
  assign o_dw    = st_dw[EXTRA_STAGES];

  // R3: a magnitude equal to the upper level is never classed as above
  a_r3_equal_not_above: assert property (@(posedge clk) disable iff (rst)
    (in_valid && THR_W'(in_mag) == in_up) |=> (st_cls[0] != CMP_ABOVE));

endmodule

// File: rtl/fdm_hold.sv
module fdm_hold
  import fdm_pkg::*;
#(
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  cmp_cls_e           in_cls,
  input  logic [DWELL_W-1:0] in_dw,
  output logic               flag
);

  logic [DWELL_W-1:0] cnt;
  logic [DWELL_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else if (in_valid) begin
      if (in_cls == CMP_ABOVE) begin
        flag <= 1'b1;
        cnt  <= '0;
      end else if (flag && in_cls == CMP_BELOW) begin
        if (cnt_inc >= {1'b0, in_dw}) begin
          flag <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt_inc[DWELL_W-1:0];
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // R3: a sample classed above the upper level sets the flag
  a_r3_set: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == CMP_ABOVE) |=> flag);

  // R5: flag cannot rise without an above-level sample
  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    (!flag && !(in_valid && in_cls == CMP_ABOVE)) |=> !flag);

  // R7: a sample between the levels keeps the flag and restarts the count
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (flag && in_valid && in_cls == CMP_MID) |=> (flag && cnt == '0));

  // R8: a dwell of one (the normalised zero) clears on a single sample
  a_r8_single: assert property (@(posedge clk) disable iff (rst)
    (flag && in_valid && in_cls == CMP_BELOW && in_dw == DWELL_W'(1)) |=> !flag);

  // R9: invalid cycles leave flag and count untouched
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(flag) && $stable(cnt)));

  // R6: the count is idle whenever the flag is low
  a_r6_count_idle: assert property (@(posedge clk) disable iff (rst)
    !flag |-> (cnt == '0));

endmodule

// File: rtl/thresh_flag_monitor.sv
module thresh_flag_monitor
  import fdm_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int THR_W   = 15,
  parameter int DWELL_W = 16,
  parameter int LATENCY = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid,
  input  logic [DATA_W-1:0]  smp_data,
  input  logic [THR_W-1:0]   thr_upper,
  input  logic [THR_W-1:0]   thr_lower,
  input  logic [DWELL_W-1:0] dwell_len,
  output logic               fast_flag
);

  localparam int MAG_W = DATA_W - 1;
  // magnitude register, compare register and flag register are fixed
  localparam int EXTRA = LATENCY - 3;

  logic               m_valid;
  logic [MAG_W-1:0]   m_mag;
  logic [THR_W-1:0]   m_up;
  logic [THR_W-1:0]   m_lo;
  logic [DWELL_W-1:0] m_dw;

  logic               c_valid;
  cmp_cls_e           c_cls;
  logic [DWELL_W-1:0] c_dw;

  fdm_magnitude #(
    .DATA_W (DATA_W),
    .THR_W  (THR_W),
    .DWELL_W(DWELL_W)
  ) u_mag (
    .clk     (clk),
    .rst     (rst),
    .in_valid(smp_valid),
    .in_data (smp_data),
    .in_up   (thr_upper),
    .in_lo   (thr_lower),
    .in_dw   (dwell_len),
    .q_valid (m_valid),
    .q_mag   (m_mag),
    .q_up    (m_up),
    .q_lo    (m_lo),
    .q_dw    (m_dw)
  );

  fdm_classify #(
    .MAG_W       (MAG_W),
    .THR_W       (THR_W),
    .DWELL_W     (DWELL_W),
    .EXTRA_STAGES(EXTRA)
  ) u_cls (
    .clk     (clk),
    .rst     (rst),
    .in_valid(m_valid),
    .in_mag  (m_mag),
    .in_up   (m_up),
    .in_lo   (m_lo),
    .in_dw   (m_dw),
    .o_valid (c_valid),
    .o_cls   (c_cls),
    .o_dw    (c_dw)
  );

  fdm_hold #(
    .DWELL_W(DWELL_W)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .in_valid(c_valid),
    .in_cls  (c_cls),
    .in_dw   (c_dw),
    .flag    (fast_flag)
  );

  // R10: reset always leaves the flag low on the next cycle
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> !fast_flag);

  initial begin
    if (LATENCY < 3) $error("LATENCY must be at least 3");
    if (THR_W < MAG_W) $error("THR_W must cover the magnitude width");
  end

endmodule

// File: tb/test_thresh_flag_monitor.sv
module test_thresh_flag_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 14;
  localparam int THR_W   = 15;
  localparam int DWELL_W = 16;
  localparam int WATCHDOG = 100000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_valid = 1'b0;
  logic [DATA_W-1:0]  smp_data = '0;
  logic [THR_W-1:0]   thr_upper = 15'd1000;
  logic [THR_W-1:0]   thr_lower = 15'd500;
  logic [DWELL_W-1:0] dwell_len = 16'd3;
  logic               fast_flag;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R10";
  bit started = 1'b0;
  bit done = 1'b0;

  thresh_flag_monitor i_thresh_flag_monitor (
    .clk      (clk),
    .rst      (rst),
    .smp_valid(smp_valid),
    .smp_data (smp_data),
    .thr_upper(thr_upper),
    .thr_lower(thr_lower),
    .dwell_len(dwell_len),
    .fast_flag(fast_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model, from the requirements ----------------
  bit m_state = 1'b0;
  int m_cnt = 0;
  bit hist [0:3] = '{default: 1'b0};

  function automatic int magnitude(input logic [DATA_W-1:0] d);
    int v;
    v = $signed(d);
    if (v < 0) v = -v;
    if (v > 8191) v = 8191;
    return v;
  endfunction

  always @(posedge clk) begin
    int m;
    int dw;
    started = 1'b1;
    if (rst) begin
      m_state = 1'b0;
      m_cnt = 0;
      for (int i = 0; i < 4; i++) hist[i] = 1'b0;
    end else begin
      if (smp_valid) begin
        m = magnitude(smp_data);
        dw = (dwell_len == 0) ? 1 : int'(dwell_len);
        if (m > int'(thr_upper)) begin
          m_state = 1'b1;
          m_cnt = 0;
        end else if (m_state && m < int'(thr_lower)) begin
          m_cnt++;
          if (m_cnt >= dw) begin
            m_state = 1'b0;
            m_cnt = 0;
          end
        end else begin
          m_cnt = 0;
        end
      end
      hist[3] = hist[2];
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = m_state;
    end
  end

  // cycle-by-cycle comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (fast_flag !== hist[3]) begin
        failures++;
        $display("FAIL %s: fast_flag actual=%b expected=%b at %0t",
                 cur_tag, fast_flag, hist[3], $time);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input int d);
    @(negedge clk);
    smp_valid = v;
    smp_data = DATA_W'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    cur_tag = "R10";
    repeat (3) @(negedge clk);
    chk("R10 reset state", fast_flag, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R4: latency of four cycles, R3 strict set
    cur_tag = "R4";
    step(1'b1, 1001);
    step(1'b0, 0); chk("R4 +1", fast_flag, 1'b0);
    step(1'b0, 0); chk("R4 +2", fast_flag, 1'b0);
    step(1'b0, 0); chk("R4 +3", fast_flag, 1'b0);
    step(1'b0, 0); chk("R4 +4", fast_flag, 1'b1);
    // R6: three below-lower samples clear, with the same latency
    cur_tag = "R6";
    step(1'b1, 10); step(1'b1, -20); step(1'b1, 0);
    step(1'b0, 0); chk("R6 +1", fast_flag, 1'b1);
    step(1'b0, 0); chk("R6 +2", fast_flag, 1'b1);
    step(1'b0, 0); chk("R6 +3", fast_flag, 1'b1);
    step(1'b0, 0); chk("R6 +4", fast_flag, 1'b0);

    // R3: equal to the upper level does not set
    cur_tag = "R3";
    step(1'b1, 1000); idle(5); chk("R3 equal", fast_flag, 1'b0);
    // R5: values just under the level keep it low
    cur_tag = "R5";
    for (int i = 0; i < 20; i++) step(1'b1, (i % 2) ? 999 : -999);
    idle(5); chk("R5 below", fast_flag, 1'b0);

    // R1: negative excursion acts like positive
    cur_tag = "R1";
    step(1'b1, -1001); idle(4); chk("R1 negative set", fast_flag, 1'b1);
    step(1'b1, 3); step(1'b1, 3); step(1'b1, 3); idle(5);
    chk("R1 cleared", fast_flag, 1'b0);

    // R2: most negative code saturates
    cur_tag = "R2";
    thr_upper = 15'd8191;
    step(1'b1, -8192); idle(5); chk("R2 not above 8191", fast_flag, 1'b0);
    thr_upper = 15'd8190;
    step(1'b1, -8192); idle(5); chk("R2 above 8190", fast_flag, 1'b1);
    step(1'b1, 0); step(1'b1, 0); step(1'b1, 0); idle(5);
    thr_upper = 15'd1000;

    // R7: mid sample one short of completion restarts the count
    cur_tag = "R7";
    step(1'b1, 2000);
    step(1'b1, 1); step(1'b1, 1); step(1'b1, 700);
    step(1'b1, 1); step(1'b1, 1); idle(6);
    chk("R7 held after restart", fast_flag, 1'b1);
    step(1'b1, 1); idle(5); chk("R7 clears after full run", fast_flag, 1'b0);

    // R9: invalid cycles with loud data neither set nor disturb the count
    cur_tag = "R9";
    for (int i = 0; i < 6; i++) step(1'b0, (i % 2) ? 8000 : -8000);
    idle(5); chk("R9 no set", fast_flag, 1'b0);
    step(1'b1, 5000); step(1'b1, 1); step(1'b1, 1);
    step(1'b0, 800); step(1'b0, 800); step(1'b1, 1); idle(5);
    chk("R9 count kept across gaps", fast_flag, 1'b0);

    // R8: zero dwell acts as one
    cur_tag = "R8";
    dwell_len = 16'd0;
    step(1'b1, 4000); idle(5); chk("R8 set", fast_flag, 1'b1);
    step(1'b1, 2); idle(5); chk("R8 single clear", fast_flag, 1'b0);
    dwell_len = 16'd3;

    // R10: reset with a sample in flight
    cur_tag = "R10";
    step(1'b1, 6000);
    step(1'b0, 0);
    rst = 1'b1;
    step(1'b0, 0); step(1'b0, 0);
    rst = 1'b0;
    idle(6); chk("R10 in-flight dropped", fast_flag, 1'b0);

    // seeded random mix around both levels
    cur_tag = "R6";
    for (int n = 0; n < 4000; n++) begin
      int up, lo, d, b;
      if (n % 250 == 0) begin
        up = 2000 + int'($urandom % 4000);
        lo = up - int'($urandom % 1500);
        thr_upper = THR_W'(up);
        thr_lower = THR_W'(lo);
        dwell_len = DWELL_W'($urandom % 6);
        cur_tag = (n % 500 == 0) ? "R7" : "R6";
      end
      up = int'(thr_upper);
      lo = int'(thr_lower);
      b = int'($urandom % 10);
      case (b)
        0: d = up + 1 + int'($urandom % 300);
        1: d = up;
        2: d = (up > 8191) ? 0 : -8192;
        3: d = 8191;
        4, 5: d = lo + int'($urandom % (up - lo + 1));
        default: d = (lo > 0) ? int'($urandom % lo) : 0;
      endcase
      if ($urandom % 2) d = -d;
      if (d < -8192) d = -8192;
      step(($urandom % 10) < 8, d);
    end
    idle(8);
    finish_run();
  end

endmodule